// File: doc/BRIEF.md
# Dual-Mode Vector Multiply-Accumulate Engine

This block is a sixteen-lane fixed-point multiply-accumulate engine for convolution and pooling work. Each cycle it can take one 256-bit vector of map values and one 256-bit vector of weights. Each vector holds sixteen signed Q8.8 elements. Element k sits at bits [16k+15:16k].

A run of consecutive accumulate steps is called a trace. The caller marks the first and last step of each trace. The mode input picks how the lanes are used:

- **Cooperative mode:** each lane handles a different input channel of one kernel, and a gather adder reduces all lanes into a single output.
- **Independent mode:** map element 0 is broadcast to every lane, each lane holds a weight from a different kernel, and sixteen outputs come back.
- **Max mode:** each lane keeps the running maximum of the map elements it sees, which serves pooling.

At the start of a trace the accumulators can be preloaded with a bias or a residual bypass vector. On writeback the accumulated value is converted back to Q8.8 with saturation.

The caller must leave at least one cycle between the final step of a cooperative trace and the final step of a following independent or max trace, because both would otherwise claim the same output cycle.

Top module: `vmac_dual`

## Requirements
- R1: With mode_i = 2'b01 (or the spare code 2'b11), output lane k is the saturated Q8.8 value of the lane's preload plus, over every step of the trace, map element 0 times weight element k.
- R2: With mode_i = 2'b00, output lane 0 is the saturated Q8.8 value of the sum over all sixteen lanes of the lane's preload plus map element k times weight element k, accumulated over the trace; output lanes 1 to 15 are zero.
- R3: res_valid_o is a one-cycle pulse per trace. In independent and max mode it rises in the cycle after the clock edge that takes the final step; in cooperative mode it rises one cycle later.
- R4: A step with first_i high discards whatever the accumulators held from earlier traces.
- R5: When pre_en_i is high on the first step, independent mode starts lane k at preload element k; cooperative mode starts lane 0 at preload element 0 and the other lanes at zero. When pre_en_i is low, all lanes start at zero.
- R6: Writeback shifts the 40-bit accumulator right arithmetically by 8 (rounding toward minus infinity) and clamps the result to the range 16'sh8000 to 16'sh7FFF.
- R7: With mode_i = 2'b10, output lane k is the largest signed map element k seen during the trace, starting from 16'sh8000. Weights and preload have no effect in this mode.
- R8: Cycles with step_i low change neither the accumulation nor res_o. res_o holds its value between valid pulses.
- R9: After reset, res_valid_o is low and res_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 cooperative, 01 independent, 10 max, 11 treated as independent |
| step_i | input | 1 | An accumulate step is taken this cycle |
| first_i | input | 1 | This step opens a trace |
| last_i | input | 1 | This step closes a trace and triggers writeback |
| map_i | input | 256 | Sixteen signed Q8.8 map elements |
| wgt_i | input | 256 | Sixteen signed Q8.8 weight elements |
| pre_en_i | input | 1 | Preload the accumulators on the first step |
| pre_i | input | 256 | Sixteen signed Q8.8 bias or bypass elements |
| res_valid_o | output | 1 | Result pulse |
| res_o | output | 256 | Sixteen signed Q8.8 results |

## Verification
The bench builds the engine with its defaults: sixteen lanes, 16-bit elements, 40-bit accumulators and 8 fraction bits. With these widths, full-scale operands push a single product past the 16-bit output range after the shift, so both clamp limits are reachable within one or two steps. The 40-bit accumulator does not wrap inside the trace lengths used, so the bench model in 64-bit integers stays exact. Random traces mix all modes, preload choices and idle bubbles. Directed traces pin the clamp limits, the rounding of small negative results and max mode with all-negative inputs.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    typedef enum logic [1:0] {
        VM_COOP = 2'd0,
        VM_INDP = 2'd1,
        VM_MAX  = 2'd2,
        VM_SPARE = 2'd3
    } vm_mode_e;

endpackage

// File: rtl/vmac_lane.sv
module vmac_lane #(
    parameter int DW   = 16,
    parameter int ACCW = 40,
    parameter int FRAC = 8
) (
    input  logic                   max_i,
    input  logic                   first_i,
    input  logic                   pre_use_i,
    input  logic signed [DW-1:0]   map_i,
    input  logic signed [DW-1:0]   wgt_i,
    input  logic signed [DW-1:0]   pre_i,
    input  logic        [ACCW-1:0] acc_i,
    output logic        [ACCW-1:0] acc_o
);
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [2*DW-1:0] prod;
    logic signed [ACCW-1:0] base;
    logic signed [ACCW-1:0] pre_ext;
    logic signed [DW-1:0]   held;
    logic signed [DW-1:0]   larger;

    always_comb begin
        prod    = map_i * wgt_i;
        pre_ext = ACCW'(pre_i);
        if (first_i) begin
            base = pre_use_i ? (pre_ext <<< FRAC) : '0;
            held = MINV;
        end else begin
            base = $signed(acc_i);
            held = $signed(acc_i[DW-1:0]);
        end
        larger = (map_i > held) ? map_i : held;
        if (max_i) begin
            acc_o = ACCW'(larger);
        end else begin
            acc_o = base + ACCW'(prod);
        end
    end
endmodule

// File: rtl/vmac_sat.sv
module vmac_sat #(
    parameter int IW   = 40,
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic [IW-1:0] val_i,
    output logic [DW-1:0] sat_o
);
    localparam logic signed [IW-1:0] HI = IW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [IW-1:0] LO = -HI - IW'(1);

    logic signed [IW-1:0] shifted;

    always_comb begin
        shifted = $signed(val_i) >>> FRAC;
        if (shifted > HI) begin
            sat_o = HI[DW-1:0];
        end else if (shifted < LO) begin
            sat_o = LO[DW-1:0];
        end else begin
            sat_o = shifted[DW-1:0];
        end
    end
endmodule

// File: rtl/vmac_gather.sv
module vmac_gather #(
    parameter int LANES = 16,
    parameter int ACCW  = 40,
    localparam int GW   = ACCW + $clog2(LANES)
) (
    input  logic [LANES-1:0][ACCW-1:0] acc_i,
    output logic [GW-1:0]              sum_o
);
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < LANES; i++) begin
            sum_o = sum_o + {{(GW-ACCW){acc_i[i][ACCW-1]}}, acc_i[i]};
        end
    end
endmodule

// File: rtl/vmac_dual.sv
module vmac_dual
    import vmac_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DW    = 16,
    parameter int ACCW  = 40,
    parameter int FRAC  = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [1:0]            mode_i,
    input  logic                  step_i,
    input  logic                  first_i,
    input  logic                  last_i,
    input  logic [LANES*DW-1:0]   map_i,
    input  logic [LANES*DW-1:0]   wgt_i,
    input  logic                  pre_en_i,
    input  logic [LANES*DW-1:0]   pre_i,
    output logic                  res_valid_o,
    output logic [LANES*DW-1:0]   res_o
);
    localparam int GW = ACCW + $clog2(LANES);

    typedef struct packed {
        logic [LANES-1:0][ACCW-1:0] acc;
        logic [LANES*DW-1:0]        res;
        logic                       vld;
        logic                       pend;
    } vm_state_t;

    vm_state_t st_d, st_q;

    vm_mode_e mode;
    logic     is_coop, is_max, is_indp;

    logic [LANES-1:0][ACCW-1:0] lane_nxt;
    logic [LANES-1:0][DW-1:0]   lane_sat;
    logic [GW-1:0]              gsum;
    logic [DW-1:0]              gsat;

    assign mode    = vm_mode_e'(mode_i);
    assign is_coop = (mode == VM_COOP);
    assign is_max  = (mode == VM_MAX);
    assign is_indp = !is_coop && !is_max;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DW-1:0] map_sel;
        logic          pre_use;
        assign map_sel = is_indp ? map_i[DW-1:0] : map_i[g*DW +: DW];
        assign pre_use = pre_en_i && (is_indp || (is_coop && (g == 0)));

        vmac_lane #(.DW(DW), .ACCW(ACCW), .FRAC(FRAC)) lane_i (
            .max_i    (is_max),
            .first_i  (first_i),
            .pre_use_i(pre_use),
            .map_i    (map_sel),
            .wgt_i    (wgt_i[g*DW +: DW]),
            .pre_i    (pre_i[g*DW +: DW]),
            .acc_i    (st_q.acc[g]),
            .acc_o    (lane_nxt[g])
        );

        vmac_sat #(.IW(ACCW), .DW(DW), .FRAC(FRAC)) sat_i (
            .val_i(lane_nxt[g]),
            .sat_o(lane_sat[g])
        );
    end

    vmac_gather #(.LANES(LANES), .ACCW(ACCW)) gather_i (
        .acc_i(st_q.acc),
        .sum_o(gsum)
    );

    vmac_sat #(.IW(GW), .DW(DW), .FRAC(FRAC)) gsat_i (
        .val_i(gsum),
        .sat_o(gsat)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.pend = 1'b0;
        if (st_q.pend) begin
            st_d.res         = '0;
            st_d.res[DW-1:0] = gsat;
            st_d.vld         = 1'b1;
        end
        if (step_i) begin
            st_d.acc = lane_nxt;
            if (last_i) begin
                if (is_coop) begin
                    st_d.pend = 1'b1;
                end else begin
                    for (int i = 0; i < LANES; i++) begin
                        st_d.res[i*DW +: DW] = is_max ? lane_nxt[i][DW-1:0] : lane_sat[i];
                    end
                    st_d.vld = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.vld;
    assign res_o       = st_q.res;

    AST_INDP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && last_i && !is_coop) |=> res_valid_o); // R3

    AST_COOP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && last_i && is_coop) |=> (!res_valid_o || st_q.pend) ##1 res_valid_o); // R3

    AST_NO_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pend |-> !(step_i && last_i && !is_coop)); // R3

    AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !res_valid_o |-> $stable(res_o)); // R8

    AST_COOP_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && $past(step_i && last_i && is_coop, 2)) |-> (res_o[LANES*DW-1:DW] == '0)); // R2
endmodule

// File: tb/vmac_dual_tb_top.sv
module vmac_dual_tb_top;
    localparam int L  = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n;
    logic [1:0]     mode;
    logic           step, first, last, pre_en;
    logic [L*DW-1:0] map_v, wgt_v, pre_v;
    logic           vld;
    logic [L*DW-1:0] res;

    vmac_dual dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .step_i(step),
        .first_i(first), .last_i(last), .map_i(map_v), .wgt_i(wgt_v),
        .pre_en_i(pre_en), .pre_i(pre_v), .res_valid_o(vld), .res_o(res)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] mv [L];
    logic [15:0] wv [L];
    logic [15:0] pv [L];
    longint macc [L];
    longint mmax [L];

    task automatic chk(input bit ok, input string req, input logic [L*DW-1:0] act,
                       input logic [L*DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] satq(input longint v);
        longint s;
        s = v >>> 8;
        if (s > 32767) s = 32767;
        else if (s < -32768) s = -32768;
        return s[15:0];
    endfunction

    function automatic logic [L*DW-1:0] expv(input int m);
        logic [L*DW-1:0] r;
        longint sum;
        r = '0;
        if (m == 0) begin
            sum = 0;
            for (int i = 0; i < L; i++) sum += macc[i];
            r[15:0] = satq(sum);
        end else begin
            for (int i = 0; i < L; i++)
                r[i*DW +: DW] = (m == 2) ? mmax[i][15:0] : satq(macc[i]);
        end
        return r;
    endfunction

    task automatic fill(input int pat);
        for (int i = 0; i < L; i++) begin
            pv[i] = 16'($urandom);
            case (pat)
                1: begin mv[i] = 16'($urandom_range(0, 511) - 256); wv[i] = 16'($urandom_range(0, 511) - 256); end
                2: begin mv[i] = 16'h7FFF; wv[i] = 16'h7FFF; end
                3: begin mv[i] = 16'hFFFF; wv[i] = 16'h0001; end
                4: begin mv[i] = 16'h8000; wv[i] = 16'h7FFF; end
                5: begin mv[i] = 16'($urandom_range(1, 30000)) ^ 16'hFFFF; wv[i] = 16'($urandom); end
                default: begin mv[i] = 16'($urandom); wv[i] = 16'($urandom); end
            endcase
        end
    endtask

    task automatic do_step(input int m, input bit f, input bit l, input bit pe);
        longint a, b;
        @(negedge clk);
        mode = 2'(m); step = 1'b1; first = f; last = l; pre_en = pe;
        for (int i = 0; i < L; i++) begin
            map_v[i*DW +: DW] = mv[i];
            wgt_v[i*DW +: DW] = wv[i];
            pre_v[i*DW +: DW] = pv[i];
        end
        for (int i = 0; i < L; i++) begin
            if (f) begin
                mmax[i] = -32768;
                macc[i] = 0;
                a = longint'($signed(pv[i]));
                if (pe && (m == 1 || m == 3)) macc[i] = a * 256;
                if (pe && m == 0 && i == 0) macc[i] = a * 256;
            end
            a = (m == 1 || m == 3) ? longint'($signed(mv[0])) : longint'($signed(mv[i]));
            b = longint'($signed(wv[i]));
            macc[i] += a * b;
            if (longint'($signed(mv[i])) > mmax[i]) mmax[i] = longint'($signed(mv[i]));
        end
    endtask

    task automatic bubble();
        logic [L*DW-1:0] prev;
        @(negedge clk);
        prev = res;
        step = 1'b0; first = $urandom_range(0, 1); last = $urandom_range(0, 1);
        map_v = {8{32'($urandom)}}; wgt_v = {8{32'($urandom)}};
        @(negedge clk);
        chk(res == prev && !vld, "R8 idle cycle", res, prev);
    endtask

    task automatic finish(input int m, input string req);
        logic [L*DW-1:0] e;
        e = expv(m);
        @(negedge clk);
        step = 1'b0; first = 1'b0; last = 1'b0;
        if (m == 0) begin
            chk(!vld, "R3 coop early valid", {255'd0, vld}, '0);
            @(negedge clk);
        end
        chk(vld, "R3 valid timing", {255'd0, vld}, {255'd0, 1'b1});
        chk(res === e, req, res, e);
        @(negedge clk);
        chk(!vld, "R3 valid pulse", {255'd0, vld}, '0);
    endtask

    task automatic run(input int m, input int len, input bit pe, input int pat,
                       input bit bub, input string req);
        for (int s = 0; s < len; s++) begin
            fill(pat);
            do_step(m, s == 0, s == len - 1, pe);
            if (bub && s < len - 1) bubble();
        end
        finish(m, req);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; mode = '0; step = 1'b0; first = 1'b0; last = 1'b0;
        pre_en = 1'b0; map_v = '0; wgt_v = '0; pre_v = '0;
        repeat (3) @(negedge clk);
        chk(!vld && res == '0, "R9 reset state", res, '0);
        rst_n = 1'b1;

        run(1, 3, 1'b1, 0, 1'b0, "R1 R5 independent with preload");
        run(1, 2, 1'b0, 1, 1'b0, "R1 R4 independent no preload");
        run(3, 2, 1'b1, 1, 1'b0, "R1 spare mode code");
        run(0, 4, 1'b1, 1, 1'b0, "R2 R5 cooperative with preload");
        run(0, 3, 1'b0, 0, 1'b0, "R2 R4 cooperative no preload");
        run(0, 2, 1'b0, 2, 1'b0, "R6 coop positive clamp");
        run(1, 1, 1'b0, 2, 1'b0, "R6 indp positive clamp");
        run(1, 2, 1'b0, 4, 1'b0, "R6 indp negative clamp");
        run(1, 1, 1'b0, 3, 1'b0, "R6 floor of small negative");
        run(2, 4, 1'b1, 5, 1'b0, "R7 max all negative, preload ignored");
        run(2, 3, 1'b0, 0, 1'b1, "R7 R8 max with bubbles");
        run(1, 4, 1'b1, 1, 1'b1, "R8 independent with bubbles");
        run(0, 4, 1'b1, 1, 1'b1, "R8 cooperative with bubbles");

        for (int t = 0; t < 60; t++) begin
            run(int'($urandom_range(0, 3)), int'($urandom_range(1, 6)), 1'($urandom),
                int'($urandom_range(0, 1)), 1'($urandom), "R4 random trace");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule